// File: doc/BRIEF.md
# Cascaded Dual Interrupt Controller

This block pairs two eight-input priority interrupt controllers, a primary and a secondary. Together they take sixteen request lines and give the processor one interrupt output and one acknowledge path. Lines 0 to 7 feed the primary. Lines 8 to 15 feed the secondary as its inputs 0 to 7. The secondary is always chained into primary input 2. Each request line is a one-cycle event strobe. The block decides, from the state of both controllers, whether each event is latched.

Software programs each controller through its own command and data port. A 2-bit address selects one of these four ports. A command write can start an initialisation sequence, select what the next status read returns, or end service of one or all inputs. Data writes complete the initialisation sequence (vector base, chaining word, option word). Outside that sequence a data write loads the mask. When the processor acknowledges, the block searches the primary first and then the secondary. In the same cycle it returns one 8-bit vector and updates the request and in-service bits. When nothing is pending it returns a spurious vector, and which controller supplies that vector depends on the primary's chained input.

Top module: `cascade_intc`

## Requirements
- R1: A primary line request (lines 0 to 7) sets its pending bit only if the line is not masked and its own in-service bit is clear.
- R2: A secondary request (lines 8 to 15 map to secondary inputs 0 to 7) is dropped unless the primary chaining word has bit 2 set and the secondary chaining word equals 2.
- R3: A secondary request is also dropped while any primary in-service bit is set, while that secondary input is in service, or while it is masked.
- R4: An accepted secondary request sets the secondary pending bit and also primary in-service bit 2, unless the primary is in automatic end-of-service mode.
- R5: With the acknowledge strobe high, the vector in that same cycle comes from the lowest pending primary input. Only if the primary has nothing pending does it come from the lowest pending secondary input, and it equals that controller's base plus the input index. The winning pending bit clears, and its in-service bit sets unless that controller uses automatic end-of-service.
- R6: If secondary input 1 wins and the secondary chaining word has been written, the vector is the primary base plus the secondary chaining word, and no secondary in-service bit is set.
- R7: With nothing pending, the acknowledge vector is the secondary base plus 7 when primary in-service bit 2 is set, and otherwise the primary base plus 7.
- R8: The interrupt output is high whenever either controller has a pending bit, so after an end-of-service command it stays high if work is still pending. It is low after reset.
- R9: A command write with bit 4 set starts initialisation. Otherwise, bit 3 set marks a status-select command, and the exact value 0x0B selects in-service for the next status read. Otherwise, bit 5 set is end-of-service: with bit 6 set it clears only the in-service bit indexed by bits 2:0, and with bit 6 clear it clears all of them.
- R10: After initialisation starts, data writes load in turn: the base (low three bits forced to zero); the chaining word, skipped when command bit 1 (single) was set; and the option word, loaded only when command bit 0 was set, whose bit 1 enables automatic end-of-service. Any other data write loads the mask.
- R11: Address 0 is the primary command port, 1 the primary data port, 2 the secondary command port and 3 the secondary data port. A command-port read returns the pending bits, or returns the in-service bits once after a 0x0B command. A data-port read returns the mask.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (consumes the in-service selection) |
| addr | input | 2 | Port select: bit 1 picks the controller, bit 0 picks data over command |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the addressed port |
| irq_req | input | 16 | Per-line request event strobes |
| ack | input | 1 | Interrupt acknowledge strobe |
| vector | output | 8 | Acknowledge vector, valid in the cycle ack is high |
| cpu_int | output | 1 | Interrupt request to the processor |

## Verification
The bench builds the block with its default parameters: eight inputs per controller, chained input 2, expected secondary chaining word 2, and secondary input 1 as the routed input. This makes the byte-wide command encodings, the forced-zero low three base bits and the input-7 spurious index the ones software actually sees. With these values the bench can program one deliberately wrong chaining word and then reach the routed-input vector, both spurious sources, and nested primary-then-secondary service. Switching the primary into automatic end-of-service separates the secondary in-service refusal from the primary-busy refusal.

// File: rtl/cic_pkg.sv
package cic_pkg;
   localparam int DATA_W = 8;

   typedef enum logic [1:0] {
      PORT_PRI_CMD  = 2'd0,
      PORT_PRI_DATA = 2'd1,
      PORT_SEC_CMD  = 2'd2,
      PORT_SEC_DATA = 2'd3
   } port_sel_e;

   // command word fields
   localparam int CMD_INIT_BIT  = 4;
   localparam int CMD_STAT_BIT  = 3;
   localparam int CMD_EOI_BIT   = 5;
   localparam int CMD_SPEC_BIT  = 6;
   localparam logic [DATA_W-1:0] CMD_SHOW_ISR = 8'h0B;

   // configuration word fields latched at init start
   localparam int CFG_SINGLE_BIT = 1;
   localparam int CFG_NEED4_BIT  = 0;

   // option word field
   localparam int OPT_AEOI_BIT = 1;
endpackage

// File: rtl/cic_first_set.sv
module cic_first_set #(
   parameter int N     = 8,
   parameter bit LOW_WINS = 1'b1
) (
   input  logic [N-1:0]         bits,
   output logic                 any,
   output logic [$clog2(N)-1:0] idx
);
   localparam int IDX_W = $clog2(N);

   assign any = |bits;

   generate
      if (LOW_WINS) begin : g_low
         always_comb begin
            idx = '0;
            for (int i = N - 1; i >= 0; i--) begin
               if (bits[i]) idx = IDX_W'(i);
            end
         end
      end else begin : g_high
         always_comb begin
            idx = '0;
            for (int i = 0; i < N; i++) begin
               if (bits[i]) idx = IDX_W'(i);
            end
         end
      end
   endgenerate
endmodule

// File: rtl/cic_prog_port.sv
module cic_prog_port
   import cic_pkg::*;
#(
   parameter int N_IN = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_wr,
   input  logic              data_wr,
   input  logic              cmd_rd,
   input  logic [DATA_W-1:0] wdata,
   output logic [N_IN-1:0]   mask,
   output logic [DATA_W-1:0] base,
   output logic [DATA_W-1:0] casc,
   output logic              casc_set,
   output logic              aeoi,
   output logic              show_isr,
   output logic [N_IN-1:0]   eoi_clr
);
   localparam int IDX_W = $clog2(N_IN);
   localparam logic [DATA_W-1:0] BASE_KEEP = {DATA_W{1'b1}} << IDX_W;

   logic              init_q;
   logic              base_pend_q;
   logic [DATA_W-1:0] cfg_q;
   logic [N_IN-1:0]   mask_q;
   logic [DATA_W-1:0] base_q;
   logic [DATA_W-1:0] casc_q;
   logic              casc_set_q;
   logic              aeoi_q;
   logic              show_q;

   logic is_init_cmd, is_stat_cmd, is_eoi_cmd;
   assign is_init_cmd = cmd_wr && wdata[CMD_INIT_BIT];
   assign is_stat_cmd = cmd_wr && !wdata[CMD_INIT_BIT] && wdata[CMD_STAT_BIT];
   assign is_eoi_cmd  = cmd_wr && !wdata[CMD_INIT_BIT] && !wdata[CMD_STAT_BIT]
                        && wdata[CMD_EOI_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         init_q      <= 1'b0;
         base_pend_q <= 1'b0;
         cfg_q       <= '0;
         mask_q      <= '0;
         base_q      <= '0;
         casc_q      <= '0;
         casc_set_q  <= 1'b0;
         aeoi_q      <= 1'b0;
         show_q      <= 1'b0;
      end else begin
         if (is_init_cmd) begin
            init_q      <= 1'b1;
            base_pend_q <= 1'b1;
            casc_set_q  <= 1'b0;
            cfg_q       <= wdata;
         end else if (is_stat_cmd) begin
            if (wdata == CMD_SHOW_ISR) show_q <= 1'b1;
         end else if (cmd_rd && show_q) begin
            show_q <= 1'b0;
         end

         if (data_wr) begin
            if (!init_q) begin
               mask_q <= wdata[N_IN-1:0];
            end else if (base_pend_q) begin
               base_q      <= wdata & BASE_KEEP;
               base_pend_q <= 1'b0;
               if (cfg_q[CFG_SINGLE_BIT] && !cfg_q[CFG_NEED4_BIT]) init_q <= 1'b0;
            end else if (!cfg_q[CFG_SINGLE_BIT] && !casc_set_q) begin
               casc_q     <= wdata;
               casc_set_q <= 1'b1;
               if (!cfg_q[CFG_NEED4_BIT]) init_q <= 1'b0;
            end else begin
               if (wdata[OPT_AEOI_BIT]) aeoi_q <= 1'b1;
               init_q <= 1'b0;
            end
         end
      end
   end

   always_comb begin
      eoi_clr = '0;
      if (is_eoi_cmd) begin
         if (wdata[CMD_SPEC_BIT]) begin
            for (int i = 0; i < N_IN; i++) begin
               eoi_clr[i] = (wdata[2:0] == 3'(i));
            end
         end else begin
            eoi_clr = '1;
         end
      end
   end

   assign mask     = mask_q;
   assign base     = base_q;
   assign casc     = casc_q;
   assign casc_set = casc_set_q;
   assign aeoi     = aeoi_q;
   assign show_isr = show_q;
endmodule

// File: rtl/cic_req_gate.sv
module cic_req_gate
   import cic_pkg::*;
#(
   parameter int N_IN     = 8,
   parameter int CASC_PIN = 2,
   parameter int CASC_ID  = 2
) (
   input  logic [2*N_IN-1:0] req,
   input  logic [N_IN-1:0]   pri_mask,
   input  logic [N_IN-1:0]   sec_mask,
   input  logic [N_IN-1:0]   pri_isr,
   input  logic [N_IN-1:0]   sec_isr,
   input  logic [DATA_W-1:0] pri_casc,
   input  logic [DATA_W-1:0] sec_casc,
   input  logic              pri_aeoi,
   output logic [N_IN-1:0]   pri_acc,
   output logic [N_IN-1:0]   sec_acc,
   output logic [N_IN-1:0]   pri_mark
);
   logic chain_ok;
   logic sec_open;

   assign chain_ok = pri_casc[CASC_PIN] && (sec_casc == DATA_W'(CASC_ID));
   assign sec_open = chain_ok && (pri_isr == '0);

   assign pri_acc = req[N_IN-1:0] & ~pri_mask & ~pri_isr;
   assign sec_acc = sec_open ? (req[2*N_IN-1:N_IN] & ~sec_mask & ~sec_isr) : '0;

   always_comb begin
      pri_mark = '0;
      if ((sec_acc != '0) && !pri_aeoi) pri_mark[CASC_PIN] = 1'b1;
   end
endmodule

// File: rtl/cascade_intc.sv
module cascade_intc
   import cic_pkg::*;
#(
   parameter int N_IN      = 8,
   parameter int CASC_PIN  = 2,
   parameter int CASC_ID   = 2,
   parameter int ROUTE_IDX = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [1:0]        addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic [2*N_IN-1:0] irq_req,
   input  logic              ack,
   output logic [DATA_W-1:0] vector,
   output logic              cpu_int
);
   localparam int N_CTL    = 2;
   localparam int IDX_W    = $clog2(N_IN);
   localparam int SPUR_IDX = N_IN - 1;

   // elaboration checks
   generate
      if (N_IN < 2 || N_IN > DATA_W || (1 << IDX_W) != N_IN) begin : g_bad_n
         $error("N_IN must be a power of two from 2 to 8");
      end
      if (CASC_PIN < 0 || CASC_PIN >= N_IN) begin : g_bad_pin
         $error("CASC_PIN out of range");
      end
      if (ROUTE_IDX < 0 || ROUTE_IDX >= N_IN) begin : g_bad_route
         $error("ROUTE_IDX out of range");
      end
      if (CASC_ID < 0 || CASC_ID >= (1 << DATA_W)) begin : g_bad_id
         $error("CASC_ID does not fit a data word");
      end
   endgenerate

   logic [N_IN-1:0]   mask_w   [N_CTL];
   logic [DATA_W-1:0] base_w   [N_CTL];
   logic [DATA_W-1:0] casc_w   [N_CTL];
   logic              cset_w   [N_CTL];
   logic              aeoi_w   [N_CTL];
   logic              show_w   [N_CTL];
   logic [N_IN-1:0]   eoi_w    [N_CTL];
   logic [N_IN-1:0]   irr_q    [N_CTL];
   logic [N_IN-1:0]   isr_q    [N_CTL];
   logic              any_w    [N_CTL];
   logic [IDX_W-1:0]  idx_w    [N_CTL];
   logic [N_IN-1:0]   ack_clr  [N_CTL];
   logic [N_IN-1:0]   ack_set  [N_CTL];
   logic [N_IN-1:0]   acc_w    [N_CTL];
   logic [N_IN-1:0]   mark_w   [N_CTL];

   genvar c;
   generate
      for (c = 0; c < N_CTL; c++) begin : g_ctl
         logic cmd_wr, data_wr, cmd_rd;
         assign cmd_wr  = wr_en && (addr == {1'(c), 1'b0});
         assign data_wr = wr_en && (addr == {1'(c), 1'b1});
         assign cmd_rd  = rd_en && (addr == {1'(c), 1'b0});

         cic_prog_port #(.N_IN(N_IN)) u_port (
            .clk      (clk),
            .rst_n    (rst_n),
            .cmd_wr   (cmd_wr),
            .data_wr  (data_wr),
            .cmd_rd   (cmd_rd),
            .wdata    (wdata),
            .mask     (mask_w[c]),
            .base     (base_w[c]),
            .casc     (casc_w[c]),
            .casc_set (cset_w[c]),
            .aeoi     (aeoi_w[c]),
            .show_isr (show_w[c]),
            .eoi_clr  (eoi_w[c])
         );

         cic_first_set #(.N(N_IN), .LOW_WINS(1'b1)) u_find (
            .bits (irr_q[c]),
            .any  (any_w[c]),
            .idx  (idx_w[c])
         );

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               irr_q[c] <= '0;
               isr_q[c] <= '0;
            end else begin
               irr_q[c] <= (irr_q[c] & ~ack_clr[c]) | acc_w[c];
               isr_q[c] <= (isr_q[c] & ~eoi_w[c]) | ack_set[c] | mark_w[c];
            end
         end
      end
   endgenerate

   logic [N_IN-1:0] sec_mark_unused;

   cic_req_gate #(
      .N_IN(N_IN), .CASC_PIN(CASC_PIN), .CASC_ID(CASC_ID)
   ) u_gate (
      .req      (irq_req),
      .pri_mask (mask_w[0]),
      .sec_mask (mask_w[1]),
      .pri_isr  (isr_q[0]),
      .sec_isr  (isr_q[1]),
      .pri_casc (casc_w[0]),
      .sec_casc (casc_w[1]),
      .pri_aeoi (aeoi_w[0]),
      .pri_acc  (acc_w[0]),
      .sec_acc  (acc_w[1]),
      .pri_mark (mark_w[0])
   );
   assign sec_mark_unused = '0;
   assign mark_w[1]       = sec_mark_unused;

   // acknowledge: vector choice and bit updates
   always_comb begin
      for (int k = 0; k < N_CTL; k++) begin
         ack_clr[k] = '0;
         ack_set[k] = '0;
      end
      if (any_w[0]) begin
         vector = base_w[0] + DATA_W'(idx_w[0]);
         if (ack) begin
            ack_clr[0][idx_w[0]] = 1'b1;
            if (!aeoi_w[0]) ack_set[0][idx_w[0]] = 1'b1;
         end
      end else if (any_w[1]) begin
         if (ack) ack_clr[1][idx_w[1]] = 1'b1;
         if ((idx_w[1] == IDX_W'(ROUTE_IDX)) && cset_w[1]) begin
            vector = base_w[0] + casc_w[1];
         end else begin
            vector = base_w[1] + DATA_W'(idx_w[1]);
            if (ack && !aeoi_w[1]) ack_set[1][idx_w[1]] = 1'b1;
         end
      end else if (isr_q[0][CASC_PIN]) begin
         vector = base_w[1] + DATA_W'(SPUR_IDX);
      end else begin
         vector = base_w[0] + DATA_W'(SPUR_IDX);
      end
   end

   assign cpu_int = any_w[0] || any_w[1];

   // register read mux
   always_comb begin
      if (addr[0]) begin
         rdata = DATA_W'(mask_w[addr[1]]);
      end else if (show_w[addr[1]]) begin
         rdata = DATA_W'(isr_q[addr[1]]);
      end else begin
         rdata = DATA_W'(irr_q[addr[1]]);
      end
   end
endmodule

// File: rtl/cascade_intc_chk.sv
module cascade_intc_chk #(
   parameter int N_IN     = 8,
   parameter int CASC_PIN = 2,
   parameter int CASC_ID  = 2
) (
   input logic            clk,
   input logic            rst_n,
   input logic            ack,
   input logic            wr_en,
   input logic            cpu_int,
   input logic [N_IN-1:0] pri_irr,
   input logic [N_IN-1:0] sec_irr,
   input logic [N_IN-1:0] pri_isr,
   input logic [N_IN-1:0] sec_isr,
   input logic            pri_aeoi,
   input logic [7:0]      pri_casc,
   input logic [7:0]      sec_casc
);
   // R2: a bad chaining pair lets no secondary request in
   assert_bad_chain_blocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!(pri_casc[CASC_PIN] && sec_casc == 8'(CASC_ID)) && !ack)
      |=> (sec_irr == $past(sec_irr)));

   // R3: primary service in progress freezes secondary pending bits
   assert_pri_busy_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ((pri_isr != '0) && !ack) |=> (sec_irr == $past(sec_irr)));

   // R4: a newly latched secondary request leaves primary input 2 in service
   assert_chain_marked_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!pri_aeoi && ((sec_irr & ~$past(sec_irr)) != '0)) |-> pri_isr[CASC_PIN]);

   // R5: a primary win leaves secondary service untouched
   assert_pri_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && (pri_irr != '0) && !wr_en) |=> (sec_isr == $past(sec_isr)));

   // R8: a raised interrupt stays raised until an acknowledge
   assert_int_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_int && !ack) |=> cpu_int);
endmodule

bind cascade_intc cascade_intc_chk #(
   .N_IN(N_IN), .CASC_PIN(CASC_PIN), .CASC_ID(CASC_ID)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .ack      (ack),
   .wr_en    (wr_en),
   .cpu_int  (cpu_int),
   .pri_irr  (irr_q[0]),
   .sec_irr  (irr_q[1]),
   .pri_isr  (isr_q[0]),
   .sec_isr  (isr_q[1]),
   .pri_aeoi (aeoi_w[0]),
   .pri_casc (casc_w[0]),
   .sec_casc (casc_w[1])
);

// File: tb/cascade_intc_tb.sv
module cascade_intc_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic        rd_en = 1'b0;
   logic [1:0]  addr = 2'd0;
   logic [7:0]  wdata = 8'd0;
   logic [7:0]  rdata;
   logic [15:0] irq_req = 16'd0;
   logic        ack = 1'b0;
   logic [7:0]  vector;
   logic        cpu_int;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #2 clk = ~clk;

   cascade_intc u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .irq_req(irq_req), .ack(ack),
      .vector(vector), .cpu_int(cpu_int)
   );

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr_en = 1'b1;
      @(posedge clk); #1 wr_en = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
      @(negedge clk);
      addr = a; rd_en = 1'b1;
      #1 check(tag, rdata, exp);
      @(posedge clk); #1 rd_en = 1'b0;
   endtask

   task automatic rd_isr(input logic [1:0] a, input logic [7:0] exp, input string tag);
      wr(a, 8'h0B);
      rd(a, exp, tag);
   endtask

   task automatic req(input logic [15:0] v);
      @(negedge clk);
      irq_req = v;
      @(posedge clk); #1 irq_req = 16'd0;
   endtask

   task automatic do_ack(input logic [7:0] exp, input string tag);
      @(negedge clk);
      ack = 1'b1;
      #1 check(tag, vector, exp);
      @(posedge clk); #1 ack = 1'b0;
   endtask

   task automatic int_is(input logic exp, input string tag);
      @(negedge clk);
      #1 check(tag, {7'd0, cpu_int}, {7'd0, exp});
   endtask

   task automatic setup_pri(input logic [7:0] opt);
      wr(2'd0, 8'h11); wr(2'd1, 8'h20); wr(2'd1, 8'h04); wr(2'd1, opt);
   endtask

   task automatic setup_sec(input logic [7:0] chain);
      wr(2'd2, 8'h11); wr(2'd3, 8'h28); wr(2'd3, chain); wr(2'd3, 8'h01);
   endtask

   task automatic t_reset;
      int_is(1'b0, "R8 reset int low");
      rd(2'd0, 8'h00, "R11 reset pending empty");
      rd(2'd1, 8'h00, "R11 reset mask clear");
      do_ack(8'h07, "R7 reset spurious vector");
   endtask

   task automatic t_bad_chain;
      setup_pri(8'h01);
      setup_sec(8'h03);
      req(16'h0400);
      rd(2'd2, 8'h00, "R2 bad chain word drops request");
      int_is(1'b0, "R2 no interrupt on bad chain");
      rd_isr(2'd0, 8'h00, "R2 primary input 2 not marked");
      setup_sec(8'h02);
   endtask

   task automatic t_pri_prio;
      req(16'h0028);
      int_is(1'b1, "R8 pending raises int");
      rd(2'd0, 8'h28, "R1 primary pending bits");
      do_ack(8'h23, "R5 lowest primary first");
      do_ack(8'h25, "R5 next primary");
      rd_isr(2'd0, 8'h28, "R9 in-service shown after 0x0B");
      rd(2'd0, 8'h00, "R11 selection used once");
      wr(2'd0, 8'h20);
      rd_isr(2'd0, 8'h00, "R9 nonspecific EOI clears all");
   endtask

   task automatic t_mask;
      wr(2'd1, 8'h10);
      rd(2'd1, 8'h10, "R10 mask write readback");
      req(16'h0010);
      rd(2'd0, 8'h00, "R1 masked line dropped");
      int_is(1'b0, "R1 masked line no int");
      wr(2'd1, 8'h00);
   endtask

   task automatic t_nested;
      req(16'h0002);
      do_ack(8'h21, "R5 primary line 1");
      req(16'h1000);
      rd(2'd2, 8'h00, "R3 primary busy drops secondary");
      wr(2'd0, 8'h20);
      req(16'h1000);
      rd(2'd2, 8'h10, "R3 secondary accepted when idle");
      rd_isr(2'd0, 8'h04, "R4 primary input 2 marked");
      int_is(1'b1, "R8 secondary pending raises int");
      do_ack(8'h2C, "R5 secondary vector");
      rd_isr(2'd2, 8'h10, "R5 secondary in service");
      do_ack(8'h2F, "R7 spurious from secondary");
      wr(2'd2, 8'h64);
      rd_isr(2'd2, 8'h00, "R9 specific EOI clears input 4");
      do_ack(8'h2F, "R7 still secondary spurious");
      wr(2'd0, 8'h20);
      do_ack(8'h27, "R7 spurious from primary");
   endtask

   task automatic t_route;
      req(16'h0200);
      do_ack(8'h22, "R6 routed input vector");
      rd_isr(2'd2, 8'h00, "R6 no secondary service");
      rd_isr(2'd0, 8'h04, "R4 routed request marks primary");
      wr(2'd0, 8'h20);
   endtask

   task automatic t_eoi_raise;
      req(16'h0008);
      do_ack(8'h23, "R5 line 3");
      int_is(1'b0, "R8 int low after ack");
      req(16'h0008);
      rd(2'd0, 8'h00, "R1 in-service line dropped");
      req(16'h0020);
      wr(2'd0, 8'h20);
      int_is(1'b1, "R8 int stays high after EOI");
      do_ack(8'h25, "R5 line 5");
      wr(2'd0, 8'h20);
   endtask

   task automatic t_auto;
      setup_pri(8'h03);
      req(16'h2000);
      rd_isr(2'd0, 8'h00, "R4 automatic mode no mark");
      do_ack(8'h2D, "R5 secondary line 13");
      rd_isr(2'd2, 8'h20, "R5 secondary in service");
      req(16'h2000);
      rd(2'd2, 8'h00, "R3 in-service secondary dropped");
      wr(2'd3, 8'h01);
      req(16'h0100);
      rd(2'd2, 8'h00, "R3 masked secondary dropped");
      wr(2'd3, 8'h00);
      req(16'h0040);
      do_ack(8'h26, "R5 primary line 6");
      rd_isr(2'd0, 8'h00, "R5 automatic mode no service bit");
      wr(2'd2, 8'h20);
   endtask

   task automatic t_single;
      wr(2'd0, 8'h12);
      wr(2'd0 | 2'd1, 8'h45);
      wr(2'd1, 8'h80);
      rd(2'd1, 8'h80, "R10 single mode ends after base");
      do_ack(8'h47, "R10 base low bits forced zero");
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset();
      t_bad_chain();
      t_pri_prio();
      t_mask();
      t_nested();
      t_route();
      t_eoi_raise();
      t_auto();
      t_single();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end
endmodule